// File: doc/BRIEF.md
# Edge-Latched Pin Event Status Unit

This block watches a bank of asynchronous input pins and records every rising edge as a sticky status bit. Each pin passes through a synchronizer. A rising edge on a pin sets that pin's bit, and the bit stays set until software acknowledges it. Software sees the bits as two 32-bit words: pins 0 to 31 in the low word, and the remaining pins in the high word at bit position pin minus 32.

Software acknowledges events through one write-1-to-clear port per word. A clear removes only the bit positions written as 1. An edge that lands in the same cycle as a clear of its own bit wins over the clear. As a result, a pin that fires again while its previous event is being acknowledged never loses the new event, and the channel never stalls.

A per-pin enable decides which status bits drive the single registered interrupt line. Masked pins still record their events.

Top module: `gpio_evt_latch`

## Requirements
- R1: While `rst` is high at a clock edge, both status words and `irq_o` become zero.
- R2: A pin that is sampled low and then high sets its status bit. The bit becomes visible on the status outputs after the third rising clock edge that samples the high level. A pin that stays steady or falls sets nothing, and a set bit stays set until it is cleared.
- R3: Pin p, for p from 32 to 39, appears at bit p-32 of `stat_hi_o`. Bits 8 to 31 of `stat_hi_o` always read zero.
- R4: When a clear-enable input is high at a clock edge, every bit of its word whose data bit is 1 becomes zero. Every other bit, in both words, is left unchanged. When the enable is low, the data has no effect.
- R5: When a new edge lands on a bit in the same cycle as a clear of that bit, the bit ends up set.
- R6: A clear applied one cycle before an edge lands leaves the bit set afterwards. A clear applied one cycle after the edge lands leaves it cleared.
- R7: A pin whose enable bit is 0 still latches its status bit but does not drive `irq_o`.
- R8: `irq_o` is registered. It is high in the cycle after any status bit with a high enable is set. It falls one cycle after the last such bit is cleared or masked.
- R9: A pin held high through reset produces no event after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 40 | Asynchronous pin inputs |
| en_i | input | 40 | Per-pin interrupt enable |
| clr_lo_we_i | input | 1 | Write enable of the low-word clear port |
| clr_lo_data_i | input | 32 | Bits to clear in the low word |
| clr_hi_we_i | input | 1 | Write enable of the high-word clear port |
| clr_hi_data_i | input | 32 | Bits to clear in the high word |
| stat_lo_o | output | 32 | Status of pins 0 to 31 |
| stat_hi_o | output | 32 | Status of pins 32 to 39 in bits 0 to 7, zero above |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The assertions check several rules on every cycle:
- an edge always lands in its bit, whatever clear arrives with it;
- bits that are not written by a clear survive;
- no bit rises without a detected edge;
- the edge pulse lasts one cycle only;
- the interrupt stays low while no enabled bit is set, and falls only after the enabled bits are gone.

Some behaviours can only be shown by the bench's scenarios:
- the three-edge latency;
- the word and bit placement of each pin;
- clears placed on adjacent cycles in both orders around an edge;
- silence after reset with pins held high.

A behavioural history model, compared on every clock through directed and random traffic, covers dense collisions between edges and clears.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int N     = 40,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] chain_q [DEPTH];
  logic [N-1:0] last_q;
  logic         armed_q;

  // Reset loads ones so that a pin already high is treated as an old level.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain_q[i] <= '1;
      last_q <= '1;
    end else begin
      chain_q[0] <= pin_i;
      for (int i = 1; i < DEPTH; i++) chain_q[i] <= chain_q[i-1];
      last_q <= chain_q[DEPTH-1];
    end
  end

  assign rise_o = chain_q[DEPTH-1] & ~last_q;

  always_ff @(posedge clk) armed_q <= !rst;

  AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (rise_o & $past(rise_o)) == '0); // R2
endmodule

// File: rtl/gpio_evt_word.sv
module gpio_evt_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] clr_mask;
  logic         armed_q;

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  // A set applied after the clear term means an edge beats an acknowledge.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | set_i;
  end

  assign stat_o = stat_q;

  always_ff @(posedge clk) armed_q <= !rst;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst || !armed_q)
    1'b1 |=> ((stat_q & $past(set_i)) == $past(set_i))); // R5
  AST_UNCLEARED_KEPT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask))); // R4
  AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (rst || !armed_q)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0)); // R2
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS   = 40,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic                clr_lo_we_i,
  input  logic [31:0]         clr_lo_data_i,
  input  logic                clr_hi_we_i,
  input  logic [31:0]         clr_hi_data_i,
  output logic [31:0]         stat_lo_o,
  output logic [31:0]         stat_hi_o,
  output logic                irq_o
);
  localparam int TOTAL_W = NUM_WORDS * WORD_W;
  localparam int PAD_W   = TOTAL_W - NUM_PINS;

  logic [NUM_PINS-1:0] rise;
  logic [TOTAL_W-1:0]  set_all;
  logic [TOTAL_W-1:0]  stat_all;
  word_t               clr_data [NUM_WORDS];
  logic                clr_we   [NUM_WORDS];
  logic                armed_q;

  gpio_evt_edge #(.N(NUM_PINS), .DEPTH(SYNC_DEPTH)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pins_i),
    .rise_o (rise)
  );

  // Unused high-word positions get no set source, so they stay at their reset zero.
  assign set_all     = {{PAD_W{1'b0}}, rise};
  assign clr_data[0] = clr_lo_data_i;
  assign clr_data[1] = clr_hi_data_i;
  assign clr_we[0]   = clr_lo_we_i;
  assign clr_we[1]   = clr_hi_we_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    gpio_evt_word #(.W(WORD_W)) u_word (
      .clk        (clk),
      .rst        (rst),
      .set_i      (set_all[w*WORD_W +: WORD_W]),
      .clr_we_i   (clr_we[w]),
      .clr_data_i (clr_data[w]),
      .stat_o     (stat_all[w*WORD_W +: WORD_W])
    );
  end

  gpio_evt_irq #(.N(NUM_PINS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .stat_i (stat_all[NUM_PINS-1:0]),
    .en_i   (en_i),
    .irq_o  (irq_o)
  );

  assign stat_lo_o = stat_all[WORD_W-1:0];
  assign stat_hi_o = stat_all[TOTAL_W-1:WORD_W];

  always_ff @(posedge clk) armed_q <= !rst;

  AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ((stat_all[NUM_PINS-1:0] & en_i) == '0) |=> !irq_o); // R7
  AST_IRQ_FALL_AFTER_LAST: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $fell(irq_o) |-> $past((stat_all[NUM_PINS-1:0] & en_i) == '0)); // R8
endmodule

// File: tb/gpio_evt_latch_bench.sv
module gpio_evt_latch_bench;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pins, en;
  logic          clr_lo_we, clr_hi_we;
  logic [31:0]   clr_lo_data, clr_hi_data;
  logic [31:0]   stat_lo, stat_hi;
  logic          irq;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 0;

  always #2 clk = ~clk;

  gpio_evt_latch u_gpio_evt_latch (
    .clk           (clk),
    .rst           (rst),
    .pins_i        (pins),
    .en_i          (en),
    .clr_lo_we_i   (clr_lo_we),
    .clr_lo_data_i (clr_lo_data),
    .clr_hi_we_i   (clr_hi_we),
    .clr_hi_data_i (clr_hi_data),
    .stat_lo_o     (stat_lo),
    .stat_hi_o     (stat_hi),
    .irq_o         (irq)
  );

  // Behavioural model: a queue of pin samples, newest first.
  logic [NP-1:0] hist [$];
  logic [63:0]   m_stat;
  logic          m_irq;

  always @(posedge clk) begin : model
    logic [NP-1:0] ev;
    logic [63:0]   mask;
    if (rst) begin
      hist.delete();
      for (int i = 0; i < 4; i++) hist.push_back('1);
      m_stat = '0;
      m_irq  = 1'b0;
    end else begin
      hist.push_front(pins);
      void'(hist.pop_back());
      ev    = hist[2] & ~hist[3];
      mask  = {clr_hi_we ? clr_hi_data : 32'h0, clr_lo_we ? clr_lo_data : 32'h0};
      m_irq = |(m_stat[NP-1:0] & en);
      m_stat = (m_stat & ~mask) | {{(64-NP){1'b0}}, ev};
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      vectors++;
      if ({stat_hi, stat_lo} !== m_stat || irq !== m_irq) begin
        fails++;
        $display("FAIL R2/R4/R8 model: stat=%h irq=%b expected stat=%h irq=%b",
                 {stat_hi, stat_lo}, irq, m_stat, m_irq);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; pins = '0; pins[5] = 1'b1; pins[35] = 1'b1; en = '1;
    clr_lo_we = 0; clr_hi_we = 0; clr_lo_data = '0; clr_hi_data = '0;
    repeat (3) tick();
    check("R1 low word in reset", stat_lo, 32'h0);
    check("R1 high word in reset", stat_hi, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    repeat (6) tick();
    check("R9 low word after reset with pin high", stat_lo, 32'h0);
    check("R9 high word after reset with pin high", stat_hi, 32'h0);
    pins[5] = 1'b0; pins[35] = 1'b0;
    repeat (3) tick();

    // R2 latency and stickiness
    pins[3] = 1'b1; tick(); tick();
    check("R2 not visible before third edge", stat_lo, 32'h0);
    tick();
    check("R2 bit 3 set", stat_lo, 32'h8);
    check("R8 irq one cycle behind status", {31'b0, irq}, 32'h0);
    tick();
    check("R8 irq asserted", {31'b0, irq}, 32'h1);
    pins[3] = 1'b0; repeat (4) tick();
    check("R2 falling edge leaves bit", stat_lo, 32'h8);

    // R3 high word placement
    pins[37] = 1'b1; pins[39] = 1'b1; tick();
    pins[37] = 1'b0; pins[39] = 1'b0; tick(); tick();
    check("R3 pins 37 and 39 in high word", stat_hi, 32'hA0);
    check("R3 low word unchanged", stat_lo, 32'h8);

    // R4 clears
    clr_lo_we = 1'b0; clr_lo_data = '1; tick();
    check("R4 data without enable ignored", stat_lo, 32'h8);
    clr_lo_we = 1'b1; clr_lo_data = 32'h8; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0;
    check("R4 low bit cleared", stat_lo, 32'h0);
    check("R4 high word untouched", stat_hi, 32'hA0);
    clr_hi_we = 1'b1; clr_hi_data = 32'h20; tick();
    clr_hi_we = 1'b0;
    check("R4 only written high bit cleared", stat_hi, 32'h80);
    clr_hi_we = 1'b1; clr_hi_data = '1; tick();
    clr_hi_we = 1'b0; clr_hi_data = '0;
    check("R4 high word cleared", stat_hi, 32'h0);
    check("R8 irq holds one cycle after clear", {31'b0, irq}, 32'h1);
    tick();
    check("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R5 edge and clear in the same cycle
    pins[10] = 1'b1; tick(); pins[10] = 1'b0; repeat (4) tick();
    check("R5 precondition bit 10", stat_lo, 32'h400);
    pins[10] = 1'b1; tick(); pins[10] = 1'b0; tick();
    clr_lo_we = 1'b1; clr_lo_data = 32'h400; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0;
    check("R5 edge beats same-cycle clear", stat_lo, 32'h400);

    // R6 clear one cycle before the edge lands
    pins[10] = 1'b1; tick(); pins[10] = 1'b0;
    clr_lo_we = 1'b1; clr_lo_data = 32'h400; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0;
    check("R6 clear before edge empties bit", stat_lo, 32'h0);
    tick();
    check("R6 edge after clear sets bit", stat_lo, 32'h400);
    // R6 clear one cycle after the edge landed
    tick();
    clr_lo_we = 1'b1; clr_lo_data = 32'h400; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0;
    check("R6 clear after edge empties bit", stat_lo, 32'h0);
    repeat (4) tick();
    check("R6 bit stays clear", stat_lo, 32'h0);

    // R7 masking
    en[20] = 1'b0; pins[20] = 1'b1; tick(); pins[20] = 1'b0; repeat (4) tick();
    check("R7 masked pin still latches", stat_lo, 32'h0010_0000);
    check("R7 masked pin gives no irq", {31'b0, irq}, 32'h0);
    en[20] = 1'b1; tick();
    check("R7 irq after unmask", {31'b0, irq}, 32'h1);
    en[20] = 1'b0; tick();
    check("R7 irq after remask", {31'b0, irq}, 32'h0);
    clr_lo_we = 1'b1; clr_lo_data = '1; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0; en = '1;

    // R2 independent pins firing together
    pins[1] = 1'b1; pins[2] = 1'b1; pins[33] = 1'b1; tick();
    pins[1] = 1'b0; pins[2] = 1'b0; pins[33] = 1'b0; repeat (3) tick();
    check("R2 simultaneous low pins", stat_lo, 32'h6);
    check("R3 simultaneous high pin", stat_hi, 32'h2);
    clr_lo_we = 1'b1; clr_lo_data = 32'h2; tick();
    clr_lo_we = 1'b0; clr_lo_data = '0;
    check("R4 one pin acknowledged", stat_lo, 32'h4);
    check("R4 other word kept", stat_hi, 32'h2);

    // Dense random traffic, checked by the model every clock
    for (int i = 0; i < 3000; i++) begin
      pins        = NP'({$urandom(), $urandom()});
      en          = NP'({$urandom(), $urandom()});
      clr_lo_we   = 1'($urandom_range(0, 1));
      clr_hi_we   = 1'($urandom_range(0, 1));
      clr_lo_data = $urandom();
      clr_hi_data = $urandom();
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule